// File: doc/BRIEF.md
# Palette DAC Clock-Synthesizer Register Port

This block is the host-side register port of a palette DAC that also carries a programmable clock synthesizer. An 8-bit bus reaches four ports: a mask/command port, a read-index port, a write-index port and a data port. A select input chooses what the index and data ports reach. With select low they reach a colour palette that stores three bytes per entry. With select high they reach a small bank of clock-synthesizer registers that store two bytes per entry.

Software reads and writes through the data port and the pointer steps by itself. It can also read back both index registers, which lets it save and restore them. Two synthesizer entries hold fixed values that identify the part. Entry 2 sets the pixel clock and entry 10 sets the memory clock. Index 0x0E is a one-byte control register. Each clock entry is an M byte (bits 6:0) followed by an N byte (N1 in bits 4:0, N2 in bits 6:5), and the output frequency is ref·(M+2)/((N1+2)·2^N2). A hidden sequence of reads on the mask/command port returns a chip ID.

Top module: `ramdac_clk_port`

## Requirements
- R1: After reset the mask reads 0xFF, the command reads 0x00, the pixel clock entry is M=0x28/N=0x61, the memory clock entry is M=0x4A/N=0x23, the control byte is 0x00, and pll_update and rd_valid are low. Both index registers are 0 after reset.
- R2: Ports are addressed as 0 = mask/command, 1 = read index, 2 = write index, 3 = data. With pll_sel low the data port reaches the palette. Its index moves on after the third byte of an entry, and palette accesses never change the clock registers.
- R3: With pll_sel high the data port reaches the clock bank. Each entry is two accesses, M first and N second, and the index moves on after the N byte. Entry 0 reads 0x28,0x61 and entry 1 reads 0x3D,0x62, and entry 10 reads its memory clock bytes.
- R4: Writes to entries 0 and 1 and to indices that are not implemented change nothing. Reading an index that is not implemented returns 0x00. The implemented indices are 0, 1, 2, 10 and 14.
- R5: A written M byte is held aside and is committed together with the N byte when the N byte is written to entry 2 or entry 10. Bit 7 of both bytes is stored as 0. pix_m and pix_n show the committed entry 2.
- R6: pll_update is high for exactly the one cycle after the clock edge that commits an N byte to entry 2, and it is low at all other times.
- R7: Index 0x0E is a single byte that drives pll_ctrl, and the index moves on after one access to it.
- R8: The read pointer and the write pointer are separate. Writing port 1 loads the read index and restarts its byte count. Writing port 2 does the same for the write index. Neither write disturbs the other pointer.
- R9: Reading port 1 returns the read index and reading port 2 returns the write index.
- R10: Port 0 writes and reads the pixel mask when pll_sel is low and the command byte when pll_sel is high.
- R11: After a read of port 2, the fourth read of port 0 returns CHIP_ID (0x70 by default) and ends the sequence. The three reads before it return the normal value. A read of port 1 or port 3 cancels the sequence, and writes do not affect it.
- R12: A read returns its byte on rdata with rd_valid high in the cycle after the access. A read and a write may fall in the same cycle: the read sees the state from before the clock edge and both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pll_sel | input | 1 | Selects the clock bank (high) or the palette (low) |
| addr | input | 2 | Port address |
| rd_en | input | 1 | Read access strobe |
| wr_en | input | 1 | Write access strobe |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, registered |
| rd_valid | output | 1 | rdata holds the result of the previous cycle's read |
| pix_mask | output | 8 | Pixel mask register |
| dac_cmd | output | 8 | Command register |
| pix_m | output | 7 | Committed pixel clock M |
| pix_n | output | 7 | Committed pixel clock N (N2 in 6:5, N1 in 4:0) |
| pll_ctrl | output | 8 | Clock control byte |
| pll_update | output | 1 | One-cycle pulse after a pixel clock commit |

## Verification
A data-port read and a data-port write can fall in the same cycle. Each uses its own pointer, so in clock mode the read can target the very entry 2 whose N byte that same write commits. The bench provokes this by aiming both pointers at entry 2 and issuing two combined read/write accesses. The reads must return the old M and N, while pix_m, pix_n and pll_update must show the new pair. A combined read and write on the read-index port is judged the same way: the old index comes back, and the next data read comes from the new index.

// File: rtl/ramdac_pkg.sv
package ramdac_pkg;

    localparam int DW        = 8;
    localparam int LUT_BYTES = 3;
    localparam int PH_W      = 2;

    typedef logic [PH_W-1:0] phase_t;
    typedef logic [DW-1:0]   byte_t;

    typedef enum logic [1:0] {
        PORT_CMD  = 2'd0,
        PORT_RIDX = 2'd1,
        PORT_WIDX = 2'd2,
        PORT_DATA = 2'd3
    } port_e;

    typedef struct packed {
        logic [6:0] m;
        logic [6:0] n;
    } pll_word_t;

    localparam logic [7:0] PLL_FIX0_IDX = 8'h00;
    localparam logic [7:0] PLL_FIX1_IDX = 8'h01;
    localparam logic [7:0] PLL_PIX_IDX  = 8'h02;
    localparam logic [7:0] PLL_MEM_IDX  = 8'h0A;
    localparam logic [7:0] PLL_CTRL_IDX = 8'h0E;

    localparam pll_word_t FIX0_WORD = '{m: 7'h28, n: 7'h61};
    localparam pll_word_t FIX1_WORD = '{m: 7'h3D, n: 7'h62};

    // Byte of a two-byte clock word: phase 0 gives M, any later phase gives N.
    function automatic byte_t word_byte(pll_word_t w, phase_t ph);
        return (ph == '0) ? {1'b0, w.m} : {1'b0, w.n};
    endfunction

    // True when the access at this phase finishes the current entry.
    function automatic logic entry_done(logic pll, logic single, phase_t ph);
        if (!pll)
            return ph >= phase_t'(LUT_BYTES - 1);
        else if (single)
            return 1'b1;
        else
            return ph >= phase_t'(1);
    endfunction

endpackage

// File: rtl/ramdac_ptr.sv
module ramdac_ptr
    import ramdac_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [IDX_W-1:0] load_val,
    input  logic             step,
    input  logic             pll_mode,
    output logic [IDX_W-1:0] idx,
    output phase_t           phase
);

    logic is_ctrl;
    logic last;

    assign is_ctrl = pll_mode && (idx == IDX_W'(PLL_CTRL_IDX));
    assign last    = entry_done(pll_mode, is_ctrl, phase);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx   <= '0;
            phase <= '0;
        end else if (load) begin
            idx   <= load_val;
            phase <= '0;
        end else if (step) begin
            if (last) begin
                idx   <= idx + 1'b1;
                phase <= '0;
            end else begin
                phase <= phase + 1'b1;
            end
        end
    end

    a_r8_phase_legal: assert property (@(posedge clk) disable iff (rst)
        phase != 2'd3);

    a_r8_load_restarts: assert property (@(posedge clk) disable iff (rst)
        load |=> (phase == '0) && (idx == $past(load_val)));

endmodule

// File: rtl/ramdac_pll_bank.sv
module ramdac_pll_bank
    import ramdac_pkg::*;
#(
    parameter int         IDX_W    = 8,
    parameter logic [6:0] PIX_M_RST = 7'h28,
    parameter logic [6:0] PIX_N_RST = 7'h61,
    parameter logic [6:0] MEM_M_RST = 7'h4A,
    parameter logic [6:0] MEM_N_RST = 7'h23,
    parameter logic [7:0] CTRL_RST  = 8'h00
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    input  phase_t           rd_phase,
    input  logic [IDX_W-1:0] wr_idx,
    input  phase_t           wr_phase,
    input  logic             we,
    input  byte_t            wdata,
    output byte_t            rbyte,
    output pll_word_t        pix_word,
    output byte_t            pll_ctrl,
    output logic             pll_update
);

    localparam pll_word_t PIX_RST = '{m: PIX_M_RST, n: PIX_N_RST};
    localparam pll_word_t MEM_RST = '{m: MEM_M_RST, n: MEM_N_RST};

    logic [6:0] stage_m;
    pll_word_t  pix_q, mem_q;
    byte_t      ctrl_q;
    logic       upd_q;

    logic w_pix, w_mem, w_ctrl, w_first, w_second;

    assign w_pix    = wr_idx == IDX_W'(PLL_PIX_IDX);
    assign w_mem    = wr_idx == IDX_W'(PLL_MEM_IDX);
    assign w_ctrl   = wr_idx == IDX_W'(PLL_CTRL_IDX);
    assign w_first  = we && (wr_phase == '0);
    assign w_second = we && (wr_phase == phase_t'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_m <= '0;
            pix_q   <= PIX_RST;
            mem_q   <= MEM_RST;
            ctrl_q  <= CTRL_RST;
            upd_q   <= 1'b0;
        end else begin
            upd_q <= 1'b0;
            if (w_first && (w_pix || w_mem))
                stage_m <= wdata[6:0];
            if (w_first && w_ctrl)
                ctrl_q <= wdata;
            if (w_second && w_pix) begin
                pix_q <= '{m: stage_m, n: wdata[6:0]};
                upd_q <= 1'b1;
            end
            if (w_second && w_mem)
                mem_q <= '{m: stage_m, n: wdata[6:0]};
        end
    end

    always_comb begin
        rbyte = '0;
        if (rd_idx == IDX_W'(PLL_FIX0_IDX))      rbyte = word_byte(FIX0_WORD, rd_phase);
        else if (rd_idx == IDX_W'(PLL_FIX1_IDX)) rbyte = word_byte(FIX1_WORD, rd_phase);
        else if (rd_idx == IDX_W'(PLL_PIX_IDX))  rbyte = word_byte(pix_q, rd_phase);
        else if (rd_idx == IDX_W'(PLL_MEM_IDX))  rbyte = word_byte(mem_q, rd_phase);
        else if (rd_idx == IDX_W'(PLL_CTRL_IDX)) rbyte = ctrl_q;
    end

    assign pix_word   = pix_q;
    assign pll_ctrl   = ctrl_q;
    assign pll_update = upd_q;

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        upd_q |=> !upd_q);

    a_r5_pix_hold: assert property (@(posedge clk) disable iff (rst)
        !(w_second && w_pix) |=> $stable(pix_q));

    a_r4_mem_hold: assert property (@(posedge clk) disable iff (rst)
        !(w_second && w_mem) |=> $stable(mem_q));

    a_r7_ctrl_hold: assert property (@(posedge clk) disable iff (rst)
        !(w_first && w_ctrl) |=> $stable(ctrl_q));

endmodule

// File: rtl/ramdac_palette.sv
module ramdac_palette
    import ramdac_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  phase_t           wphase,
    input  byte_t            wdata,
    input  logic [IDX_W-1:0] ridx,
    input  phase_t           rphase,
    output byte_t            rbyte
);

    localparam int DEPTH = 1 << IDX_W;

    byte_t lane_out [LUT_BYTES];

    for (genvar b = 0; b < LUT_BYTES; b++) begin : g_lane
        byte_t store [DEPTH];
        always_ff @(posedge clk) begin
            if (we && (wphase == phase_t'(b)))
                store[widx] <= wdata;
        end
        assign lane_out[b] = store[ridx];
    end

    always_comb begin
        rbyte = '0;
        for (int b = 0; b < LUT_BYTES; b++)
            if (rphase == phase_t'(b))
                rbyte = lane_out[b];
    end

endmodule

// File: rtl/ramdac_id_seq.sv
module ramdac_id_seq
    import ramdac_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rd_en,
    input  port_e port,
    output logic  hit
);

    logic       armed;
    logic [1:0] cnt;

    assign hit = rd_en && (port == PORT_CMD) && armed && (cnt == 2'd3);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (rd_en) begin
            unique case (port)
                PORT_WIDX: begin
                    armed <= 1'b1;
                    cnt   <= '0;
                end
                PORT_CMD: begin
                    if (armed) begin
                        if (cnt == 2'd3) armed <= 1'b0;
                        else             cnt   <= cnt + 1'b1;
                    end
                end
                default: armed <= 1'b0;
            endcase
        end
    end

    a_r11_disarm_after_id: assert property (@(posedge clk) disable iff (rst)
        hit |=> !armed);

    a_r11_arm_on_widx: assert property (@(posedge clk) disable iff (rst)
        (rd_en && port == PORT_WIDX) |=> (armed && cnt == '0));

endmodule

// File: rtl/ramdac_clk_port.sv
module ramdac_clk_port
    import ramdac_pkg::*;
#(
    parameter int         IDX_W     = 8,
    parameter logic [7:0] CHIP_ID   = 8'h70,
    parameter logic [7:0] MASK_RST  = 8'hFF,
    parameter logic [7:0] CMD_RST   = 8'h00,
    parameter logic [6:0] PIX_M_RST = 7'h28,
    parameter logic [6:0] PIX_N_RST = 7'h61,
    parameter logic [6:0] MEM_M_RST = 7'h4A,
    parameter logic [6:0] MEM_N_RST = 7'h23
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pll_sel,
    input  logic [1:0] addr,
    input  logic       rd_en,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       rd_valid,
    output logic [7:0] pix_mask,
    output logic [7:0] dac_cmd,
    output logic [6:0] pix_m,
    output logic [6:0] pix_n,
    output logic [7:0] pll_ctrl,
    output logic       pll_update
);

    port_e port;
    assign port = port_e'(addr);

    logic rd_data, wr_data;
    assign rd_data = rd_en && (port == PORT_DATA);
    assign wr_data = wr_en && (port == PORT_DATA);

    logic [IDX_W-1:0] ridx, widx;
    phase_t           rph, wph;

    ramdac_ptr #(.IDX_W(IDX_W)) u_rptr (
        .clk(clk), .rst(rst),
        .load(wr_en && port == PORT_RIDX), .load_val(wdata[IDX_W-1:0]),
        .step(rd_data), .pll_mode(pll_sel),
        .idx(ridx), .phase(rph)
    );

    ramdac_ptr #(.IDX_W(IDX_W)) u_wptr (
        .clk(clk), .rst(rst),
        .load(wr_en && port == PORT_WIDX), .load_val(wdata[IDX_W-1:0]),
        .step(wr_data), .pll_mode(pll_sel),
        .idx(widx), .phase(wph)
    );

    byte_t     pll_byte, lut_byte;
    pll_word_t pix_word;

    ramdac_pll_bank #(
        .IDX_W(IDX_W),
        .PIX_M_RST(PIX_M_RST), .PIX_N_RST(PIX_N_RST),
        .MEM_M_RST(MEM_M_RST), .MEM_N_RST(MEM_N_RST)
    ) u_bank (
        .clk(clk), .rst(rst),
        .rd_idx(ridx), .rd_phase(rph),
        .wr_idx(widx), .wr_phase(wph),
        .we(wr_data && pll_sel), .wdata(wdata),
        .rbyte(pll_byte), .pix_word(pix_word),
        .pll_ctrl(pll_ctrl), .pll_update(pll_update)
    );

    ramdac_palette #(.IDX_W(IDX_W)) u_lut (
        .clk(clk),
        .we(wr_data && !pll_sel), .widx(widx), .wphase(wph), .wdata(wdata),
        .ridx(ridx), .rphase(rph), .rbyte(lut_byte)
    );

    logic id_hit;

    ramdac_id_seq u_id (
        .clk(clk), .rst(rst), .rd_en(rd_en), .port(port), .hit(id_hit)
    );

    byte_t mask_q, cmd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= MASK_RST;
            cmd_q  <= CMD_RST;
        end else if (wr_en && port == PORT_CMD) begin
            if (pll_sel) cmd_q  <= wdata;
            else         mask_q <= wdata;
        end
    end

    byte_t rd_next;

    always_comb begin
        unique case (port)
            PORT_CMD:  rd_next = id_hit ? CHIP_ID : (pll_sel ? cmd_q : mask_q);
            PORT_RIDX: rd_next = byte_t'(ridx);
            PORT_WIDX: rd_next = byte_t'(widx);
            default:   rd_next = pll_sel ? pll_byte : lut_byte;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata    <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rdata <= rd_next;
        end
    end

    assign pix_mask = mask_q;
    assign dac_cmd  = cmd_q;
    assign pix_m    = pix_word.m;
    assign pix_n    = pix_word.n;

    a_r12_valid_follows: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    a_r12_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid);

    a_r10_mask_hold: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && port == PORT_CMD && !pll_sel) |=> $stable(mask_q));

    a_r10_cmd_hold: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && port == PORT_CMD && pll_sel) |=> $stable(cmd_q));

    a_r6_update_needs_clock_write: assert property (@(posedge clk) disable iff (rst)
        $rose(pll_update) |-> $past(wr_data && pll_sel));

endmodule

// File: tb/sim_ramdac_clk_port.sv
module sim_ramdac_clk_port;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pll_sel = 1'b0;
    logic [1:0] addr = '0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rd_valid;
    logic [7:0] pix_mask, dac_cmd, pll_ctrl;
    logic [6:0] pix_m, pix_n;
    logic       pll_update;

    always #2.5 clk = ~clk;

    ramdac_clk_port u0 (
        .clk(clk), .rst(rst), .pll_sel(pll_sel), .addr(addr),
        .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .rd_valid(rd_valid),
        .pix_mask(pix_mask), .dac_cmd(dac_cmd),
        .pix_m(pix_m), .pix_n(pix_n),
        .pll_ctrl(pll_ctrl), .pll_update(pll_update)
    );

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    // Driver: one access per call, issued at a falling edge.
    task automatic acc(input logic s, input logic r, input logic w,
                       input logic [1:0] a, input logic [7:0] d,
                       input logic [7:0] e, input string tag);
        @(negedge clk);
        pll_sel = s; addr = a; rd_en = r; wr_en = w; wdata = d;
        if (r) begin
            exp_q.push_back(e);
            tag_q.push_back(tag);
        end
    endtask

    task automatic wr(input logic s, input logic [1:0] a, input logic [7:0] d);
        acc(s, 1'b0, 1'b1, a, d, 8'h00, "");
    endtask

    task automatic rd(input logic s, input logic [1:0] a, input logic [7:0] e, input string tag);
        acc(s, 1'b1, 1'b0, a, 8'h00, e, tag);
    endtask

    task automatic idle();
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
    endtask

    // Monitor: compares each returned byte with the oldest expected item.
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R12: unexpected read data %02h expected none", rdata);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(rdata, e, t);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got hang expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        chk(pix_mask, 8'hFF, "R1 mask");
        chk(dac_cmd, 8'h00, "R1 command");
        chk({1'b0, pix_m}, 8'h28, "R1 pix_m");
        chk({1'b0, pix_n}, 8'h61, "R1 pix_n");
        chk(pll_ctrl, 8'h00, "R1 ctrl");
        chk({7'b0, pll_update}, 8'h00, "R1 pll_update");
        chk({7'b0, rd_valid}, 8'h00, "R1 rd_valid");

        // R3 fixed entries read in order, R9 read index readback
        wr(1, 1, 8'h00);
        rd(1, 3, 8'h28, "R3 fix0 M");
        rd(1, 3, 8'h61, "R3 fix0 N");
        rd(1, 3, 8'h3D, "R3 fix1 M");
        rd(1, 3, 8'h62, "R3 fix1 N");
        rd(1, 1, 8'h02, "R9 read index");

        // R5 staging, R6 pulse
        wr(1, 2, 8'h02);
        wr(1, 3, 8'h85);
        idle();
        chk({1'b0, pix_m}, 8'h28, "R5 M staged only");
        chk({7'b0, pll_update}, 8'h00, "R6 no pulse on M");
        wr(1, 3, 8'hE3);
        idle();
        chk({1'b0, pix_m}, 8'h05, "R5 pix_m commit");
        chk({1'b0, pix_n}, 8'h63, "R5 pix_n commit");
        chk({7'b0, pll_update}, 8'h01, "R6 pulse");
        idle();
        chk({7'b0, pll_update}, 8'h00, "R6 pulse ends");
        wr(1, 1, 8'h02);
        rd(1, 3, 8'h05, "R5 readback M bit7 clear");
        rd(1, 3, 8'h63, "R5 readback N bit7 clear");

        // R4 read-only and absent entries
        wr(1, 2, 8'h00);
        wr(1, 3, 8'h11);
        wr(1, 3, 8'h22);
        wr(1, 1, 8'h00);
        rd(1, 3, 8'h28, "R4 fix0 M unchanged");
        rd(1, 3, 8'h61, "R4 fix0 N unchanged");
        wr(1, 2, 8'h05);
        wr(1, 3, 8'hAA);
        wr(1, 3, 8'hBB);
        wr(1, 1, 8'h05);
        rd(1, 3, 8'h00, "R4 absent M");
        rd(1, 3, 8'h00, "R4 absent N");

        // R7 single-byte control entry
        wr(1, 2, 8'h0E);
        wr(1, 3, 8'hA5);
        wr(1, 3, 8'h77);
        idle();
        chk(pll_ctrl, 8'hA5, "R7 ctrl written");
        rd(1, 2, 8'h0F, "R7 write index after one byte");
        wr(1, 1, 8'h0E);
        rd(1, 3, 8'hA5, "R7 ctrl read");
        rd(1, 3, 8'h00, "R7 next entry absent");
        rd(1, 1, 8'h0F, "R9 read index after ctrl");

        // R3 memory clock entry
        wr(1, 1, 8'h0A);
        rd(1, 3, 8'h4A, "R3 mem M");
        rd(1, 3, 8'h23, "R3 mem N");

        // R2 palette, three bytes per entry
        wr(0, 2, 8'h05);
        for (int i = 0; i < 6; i++) wr(0, 3, 8'h10 + 8'(i));
        rd(0, 2, 8'h07, "R2 write index after two entries");
        wr(0, 1, 8'h05);
        for (int i = 0; i < 6; i++) rd(0, 3, 8'h10 + 8'(i), "R2 palette byte");
        idle();
        chk({1'b0, pix_m}, 8'h05, "R2 palette leaves clock alone");

        // R8 separate pointers
        wr(0, 1, 8'h06);
        rd(0, 3, 8'h13, "R8 first byte");
        wr(0, 1, 8'h06);
        rd(0, 3, 8'h13, "R8 phase restart");
        rd(0, 3, 8'h14, "R8 next byte");
        wr(0, 2, 8'h09);
        wr(0, 3, 8'h40);
        wr(0, 1, 8'h09);
        rd(0, 3, 8'h40, "R8 write pointer own index");
        wr(0, 1, 8'h05);
        rd(0, 3, 8'h10, "R8 read byte 0");
        wr(0, 2, 8'h20);
        rd(0, 3, 8'h11, "R8 write-index load leaves read phase");

        // R10 mask and command
        wr(1, 0, 8'h50);
        idle();
        chk(dac_cmd, 8'h50, "R10 command write");
        chk(pix_mask, 8'hFF, "R10 mask untouched");
        wr(0, 0, 8'h0F);
        idle();
        chk(pix_mask, 8'h0F, "R10 mask write");
        chk(dac_cmd, 8'h50, "R10 command untouched");
        rd(1, 0, 8'h50, "R10 command read");
        rd(0, 0, 8'h0F, "R10 mask read");

        // R11 chip ID sequence
        wr(0, 2, 8'h03);
        rd(0, 2, 8'h03, "R11 arm");
        rd(0, 0, 8'h0F, "R11 read 1");
        rd(0, 0, 8'h0F, "R11 read 2");
        rd(0, 0, 8'h0F, "R11 read 3");
        rd(0, 0, 8'h70, "R11 chip id");
        rd(0, 0, 8'h0F, "R11 after id");
        rd(0, 2, 8'h03, "R11 arm again");
        rd(0, 0, 8'h0F, "R11 read 1b");
        rd(0, 0, 8'h0F, "R11 read 2b");
        rd(0, 1, 8'h05, "R11 cancel by index read");
        rd(0, 0, 8'h0F, "R11 cancelled 3");
        rd(0, 0, 8'h0F, "R11 cancelled 4");
        rd(0, 2, 8'h03, "R11 arm third");
        rd(0, 0, 8'h0F, "R11 read 1c");
        wr(0, 1, 8'h05);
        rd(0, 0, 8'h0F, "R11 read 2c");
        rd(0, 0, 8'h0F, "R11 read 3c");
        rd(0, 0, 8'h70, "R11 id despite write");
        rd(1, 2, 8'h03, "R11 arm clock mode");
        rd(1, 0, 8'h50, "R11 cmd 1");
        rd(1, 0, 8'h50, "R11 cmd 2");
        rd(1, 0, 8'h50, "R11 cmd 3");
        rd(1, 0, 8'h70, "R11 id clock mode");

        // R12 read and write in the same cycle
        wr(1, 2, 8'h02);
        wr(1, 1, 8'h02);
        acc(1, 1, 1, 3, 8'h11, 8'h05, "R12 old M during write");
        acc(1, 1, 1, 3, 8'h22, 8'h63, "R12 old N during commit");
        idle();
        chk({1'b0, pix_m}, 8'h11, "R12 new pix_m");
        chk({1'b0, pix_n}, 8'h22, "R12 new pix_n");
        chk({7'b0, pll_update}, 8'h01, "R12 pulse on combined access");
        acc(1, 1, 1, 1, 8'h0A, 8'h03, "R12 old read index");
        rd(1, 3, 8'h4A, "R12 new read index used");
        wr(1, 1, 8'h02);
        rd(1, 3, 8'h11, "R12 readback M");
        rd(1, 3, 8'h22, "R12 readback N");

        idle();
        idle();
        idle();
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R12: got %0d missing reads expected 0", exp_q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule